// File: doc/BRIEF.md
# Clock-Domain Watchdog Countdown with Reset Pulse

This block is the watchdog of a real-time clock. A free-running prescaler divides a 4096 Hz reference enable into slower ticks. A byte-wide countdown decrements on the tick that software selects. Software reaches the block over a simple byte bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data.

Two registers hold the watchdog. The control byte picks the tick rate and whether expiry resets the system. The value byte loads and starts the countdown. Writing zero to the value byte stops it. Rewriting a non-zero value while the count runs is the keep-alive. A read of the second control register also stops a running countdown. Software must then write the value again to resume.

In watchdog mode the count can reach zero. The active-low reset output then drops for a fixed number of reference pulses and rises again. After that the timer stays stopped.

The controller has three states:
- IDLE: stopped.
- RUN: counting.
- FIRE: the reset pulse is being driven.

Its transitions are:
- START: IDLE to RUN on a non-zero value write.
- RELOAD: RUN to RUN on a non-zero value write.
- HALT_WRITE: RUN to IDLE on a zero value write.
- HALT_READ: RUN to IDLE on a read of the second control register.
- EXPIRE_FIRE: RUN to FIRE when the count reaches zero in watchdog mode.
- EXPIRE_QUIET: RUN to IDLE when the count reaches zero in any other mode.
- RELEASE: FIRE to IDLE after PULSE_LEN reference pulses.

Top module: `rtc_wdt`

## Requirements
- R1: After reset the control byte reads 0x00, the count reads 0, the timer is stopped and `wd_rst_n` is high.
- R2: A write to address 0x10 stores bits [7:6] and [1:0]. A read of 0x10 returns those bits with bits [5:2] as zero. A read of any address other than 0x10 or 0x11, and any cycle without a read strobe, returns 0x00.
- R3: Control bits [1:0] select the tick source:
  - 00 ticks on every reference pulse.
  - 01 ticks every DIV_MID pulses.
  - 10 ticks every DIV_MID*DIV_SEC pulses.
  - 11 ticks every DIV_MID*DIV_SEC*DIV_MIN pulses.
  The prescaler counts from reset, so the n-th pulse after reset is a tick when n is a multiple of the divisor.
- R4: A non-zero write to address 0x11 loads the count and starts the countdown. Each selected tick then decrements the count by one. A read of 0x11 returns the current count.
- R5: A write of 0 to address 0x11 stops the timer and clears the count. No reset pulse follows, and the count stays at 0 on later ticks.
- R6: A non-zero write to address 0x11 while the count runs reloads it (keep-alive). The write wins over a tick in the same cycle.
- R7: A read of address 0x01 while the count runs stops it and holds the count. This also applies when the read falls in the same cycle as a tick.
- R8: In watchdog mode (control bits [7:6] = 11), a tick that brings the count to 0 drives `wd_rst_n` low from the next cycle. It stays low until PULSE_LEN reference pulses have been seen in that state. It then returns high with the timer stopped.
- R9: When the count reaches 0 with control bits [7:6] not equal to 11, the timer stops and `wd_rst_n` stays high.
- R10: While `wd_rst_n` is low, value writes and reads of 0x01 are ignored, and the count reads 0.
- R11: Control writes alone never start the countdown. The count stays 0 until a non-zero value is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle pulse at the 4096 Hz reference rate |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| wd_rst_n | output | 1 | Active-low reset output on expiry |

## Verification
The collisions that matter are between a selected tick and a bus access in the same cycle. Either a keep-alive write or a stopping read can land on the tick. With the fastest source selected, the reference enable alternates every cycle. A keep-alive rewritten every third cycle therefore falls on both tick and non-tick cycles, and so do back-to-back stopping reads. A behavioural model, in which the write and the stopping read take priority over the decrement, predicts the count and the reset output every cycle. A mismatch in either one on any cycle is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_e;

    localparam logic [7:0] ADDR_WCTL = 8'h10;
    localparam logic [7:0] ADDR_WVAL = 8'h11;
    localparam logic [7:0] ADDR_CTL2 = 8'h01;

    localparam logic [1:0] MODE_WATCHDOG = 2'b11;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned DIV_MID = 64,
    parameter int unsigned DIV_SEC = 64,
    parameter int unsigned DIV_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int unsigned NSTAGE = 3;
    localparam int unsigned MAXDIV = (DIV_MID > DIV_SEC) ?
        ((DIV_MID > DIV_MIN) ? DIV_MID : DIV_MIN) :
        ((DIV_SEC > DIV_MIN) ? DIV_SEC : DIV_MIN);
    localparam int unsigned CW = $clog2(MAXDIV + 1);

    logic [NSTAGE:0] en;
    assign en[0] = ref_en;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        localparam int unsigned D = (i == 0) ? DIV_MID : (i == 1) ? DIV_SEC : DIV_MIN;
        logic [CW-1:0] cnt_q;
        logic          wrap;

        assign wrap      = (cnt_q == CW'(D - 1));
        assign en[i + 1] = en[i] && wrap;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (en[i]) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign tick = en[sel];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] cnt,
    output logic [1:0]       src_sel,
    output logic             wd_mode,
    output logic             val_wr,
    output logic [CNT_W-1:0] val_data,
    output logic             stop_rd,
    output logic [7:0]       bus_rdata
);
    logic [1:0] mode_q;
    logic [1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            src_q  <= 2'b00;
        end else if (bus_wr && bus_addr == ADDR_WCTL) begin
            mode_q <= bus_wdata[7:6];
            src_q  <= bus_wdata[1:0];
        end
    end

    assign src_sel  = src_q;
    assign wd_mode  = (mode_q == MODE_WATCHDOG);
    assign val_wr   = bus_wr && (bus_addr == ADDR_WVAL);
    assign val_data = bus_wdata[CNT_W-1:0];
    assign stop_rd  = bus_rd && (bus_addr == ADDR_CTL2);

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_WCTL: bus_rdata = {mode_q, 4'b0000, src_q};
                ADDR_WVAL: bus_rdata = 8'(cnt);
                default:   bus_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             tick,
    input  logic             wd_mode,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_data,
    input  logic             stop_rd,
    output logic [CNT_W-1:0] cnt,
    output wdt_state_e       state,
    output logic             wd_rst_n
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PW-1:0]    pulse_q, pulse_d;
    logic             load_nz;
    logic             last_tick;

    assign load_nz   = val_wr && (val_data != '0);
    assign last_tick = tick && (cnt_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_nz) state_d = ST_RUN;              // START
            end
            ST_RUN: begin
                if (val_wr) begin
                    state_d = load_nz ? ST_RUN : ST_IDLE;   // RELOAD / HALT_WRITE
                end else if (stop_rd) begin
                    state_d = ST_IDLE;                      // HALT_READ
                end else if (last_tick) begin
                    state_d = wd_mode ? ST_FIRE : ST_IDLE;  // EXPIRE_FIRE / EXPIRE_QUIET
                end
            end
            ST_FIRE: begin
                if (ref_en && pulse_q == PW'(PULSE_LEN - 1)) begin
                    state_d = ST_IDLE;                      // RELEASE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Count and pulse datapath
    always_comb begin
        cnt_d   = cnt_q;
        pulse_d = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (val_wr) cnt_d = val_data;
            end
            ST_RUN: begin
                if (val_wr) begin
                    cnt_d = val_data;
                end else if (!stop_rd && tick) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_FIRE: begin
                if (ref_en) pulse_d = pulse_q + 1'b1;
                else        pulse_d = pulse_q;
                if (state_d != ST_FIRE) pulse_d = '0;
            end
            default: cnt_d = '0;
        endcase
    end

    // Outputs
    always_comb begin
        cnt      = cnt_q;
        state    = state_q;
        wd_rst_n = (state_q != ST_FIRE);
    end
endmodule

// File: rtl/rtc_wdt.sv
module rtc_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned DIV_MID   = 64,
    parameter int unsigned DIV_SEC   = 64,
    parameter int unsigned DIV_MIN   = 60,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       wd_rst_n
);
    localparam int unsigned CNT_W = 8;

    logic [1:0]       src_sel;
    logic             wd_mode;
    logic             val_wr;
    logic [CNT_W-1:0] val_data;
    logic             stop_rd;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    wdt_state_e       st;

    wdt_prescaler #(
        .DIV_MID(DIV_MID),
        .DIV_SEC(DIV_SEC),
        .DIV_MIN(DIV_MIN)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .sel    (src_sel),
        .tick   (tick)
    );

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .cnt       (cnt),
        .src_sel   (src_sel),
        .wd_mode   (wd_mode),
        .val_wr    (val_wr),
        .val_data  (val_data),
        .stop_rd   (stop_rd),
        .bus_rdata (bus_rdata)
    );

    wdt_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (ref_en),
        .tick     (tick),
        .wd_mode  (wd_mode),
        .val_wr   (val_wr),
        .val_data (val_data),
        .stop_rd  (stop_rd),
        .cnt      (cnt),
        .state    (st),
        .wd_rst_n (wd_rst_n)
    );
endmodule

// File: rtl/rtc_wdt_chk.sv
module rtc_wdt_chk
    import wdt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ref_en,
    input logic       wd_rst_n,
    input wdt_state_e st,
    input logic [7:0] cnt,
    input logic       tick,
    input logic       val_wr,
    input logic [7:0] val_data,
    input logic       stop_rd,
    input logic       wd_mode
);
    p_dec_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && tick && !val_wr && !stop_rd && cnt > 8'd1) |=> (cnt == $past(cnt) - 8'd1))
        else $error("p_dec_by_one_r4");

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !val_wr) |=> (st == ST_IDLE && $stable(cnt)))
        else $error("p_idle_hold_r5");

    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_FIRE && val_wr && val_data != 8'd0) |=> (st == ST_RUN && cnt == $past(val_data)))
        else $error("p_load_wins_r6");

    p_read_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && stop_rd && !val_wr) |=> (st == ST_IDLE && $stable(cnt)))
        else $error("p_read_stop_r7");

    p_fire_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> ($past(st) == ST_RUN && $past(tick) && $past(cnt) == 8'd1
                             && $past(wd_mode) && !$past(val_wr) && !$past(stop_rd)))
        else $error("p_fire_cause_r8");

    p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_rst_n && !ref_en) |=> !wd_rst_n)
        else $error("p_hold_low_r8");

    p_quiet_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && tick && cnt == 8'd1 && !wd_mode && !val_wr && !stop_rd) |=> (wd_rst_n && st == ST_IDLE))
        else $error("p_quiet_expiry_r9");

    p_fire_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRE) |=> (cnt == 8'd0))
        else $error("p_fire_ignore_r10");
endmodule

bind rtc_wdt rtc_wdt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .wd_rst_n (wd_rst_n),
    .st       (st),
    .cnt      (cnt),
    .tick     (tick),
    .val_wr   (val_wr),
    .val_data (val_data),
    .stop_rd  (stop_rd),
    .wd_mode  (wd_mode)
);

// File: tb/rtc_wdt_tb.sv
`timescale 1ns/1ps
module rtc_wdt_tb;
    localparam int DM = 4;
    localparam int DS = 3;
    localparam int DN = 2;
    localparam int PL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       wd_rst_n;

    always #2 clk = ~clk;

    rtc_wdt #(.DIV_MID(DM), .DIV_SEC(DS), .DIV_MIN(DN), .PULSE_LEN(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .wd_rst_n(wd_rst_n)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference: 0 stopped, 1 counting, 2 pulsing
    int m_st = 0;
    int m_cnt = 0;
    int m_pulse = 0;
    int m_refs = 0;
    int m_ctrl = 0;
    bit phase = 0;

    task automatic check(string t, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic [7:0] d, input bit w, input bit r);
        int  exp_rd;
        bit  t;
        bit  wv;
        bit  sr;
        int  src;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
        ref_en = phase;
        phase = ~phase;
        #1;
        exp_rd = 0;
        if (r) begin
            if (a == 8'h10)      exp_rd = m_ctrl;
            else if (a == 8'h11) exp_rd = m_cnt;
        end
        check(tag, bus_rdata, exp_rd, "rdata");
        check(tag, wd_rst_n, (m_st != 2) ? 1 : 0, "wd_rst_n");
        @(posedge clk);
        t = 0;
        src = m_ctrl & 3;
        if (ref_en) begin
            m_refs++;
            case (src)
                0: t = 1;
                1: t = (m_refs % DM) == 0;
                2: t = (m_refs % (DM * DS)) == 0;
                default: t = (m_refs % (DM * DS * DN)) == 0;
            endcase
        end
        wv = w && (a == 8'h11);
        sr = r && (a == 8'h01);
        if (m_st == 2) begin
            if (ref_en) begin
                m_pulse++;
                if (m_pulse == PL) begin m_st = 0; m_pulse = 0; end
            end
        end else if (wv) begin
            m_cnt = d;
            m_st = (d != 0) ? 1 : 0;
        end else if (m_st == 1) begin
            if (sr) m_st = 0;
            else if (t) begin
                m_cnt--;
                if (m_cnt == 0) m_st = ((m_ctrl & 8'hC0) == 8'hC0) ? 2 : 0;
            end
        end
        if (w && a == 8'h10) m_ctrl = d & 8'hC3;
    endtask

    task automatic idle_read(int n);
        for (int i = 0; i < n; i++) cyc(8'h11, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", wd_rst_n, 1, "wd_rst_n in reset");
        rst_n = 1'b1;
        // R1: state after reset
        tag = "R1";
        cyc(8'h10, 8'h00, 1'b0, 1'b1);
        cyc(8'h11, 8'h00, 1'b0, 1'b1);
        idle_read(4);
        // R2: control storage and masking, other addresses read zero
        tag = "R2";
        cyc(8'h10, 8'hFF, 1'b1, 1'b0);
        cyc(8'h10, 8'h00, 1'b0, 1'b1);
        cyc(8'h10, 8'h42, 1'b1, 1'b0);
        cyc(8'h10, 8'h00, 1'b0, 1'b1);
        cyc(8'h05, 8'h00, 1'b0, 1'b1);
        cyc(8'h10, 8'h00, 1'b0, 1'b0);
        // R11: configuration alone never starts counting
        tag = "R11";
        cyc(8'h10, 8'hC0, 1'b1, 1'b0);
        idle_read(12);
        // R4 / R9: fast source, quiet mode, count to zero
        tag = "R4";
        cyc(8'h10, 8'h00, 1'b1, 1'b0);
        cyc(8'h11, 8'd5, 1'b1, 1'b0);
        idle_read(8);
        tag = "R9";
        idle_read(10);
        // R3: every tick source
        tag = "R3";
        cyc(8'h10, 8'h01, 1'b1, 1'b0);
        cyc(8'h11, 8'd3, 1'b1, 1'b0);
        idle_read(40);
        cyc(8'h10, 8'h02, 1'b1, 1'b0);
        cyc(8'h11, 8'd2, 1'b1, 1'b0);
        idle_read(70);
        cyc(8'h10, 8'h03, 1'b1, 1'b0);
        cyc(8'h11, 8'd2, 1'b1, 1'b0);
        idle_read(130);
        // R5: zero write stops, no pulse
        tag = "R5";
        cyc(8'h10, 8'hC0, 1'b1, 1'b0);
        cyc(8'h11, 8'd6, 1'b1, 1'b0);
        idle_read(3);
        cyc(8'h11, 8'd0, 1'b1, 1'b0);
        idle_read(20);
        // R6: keep-alive rewrites on tick and non-tick cycles
        tag = "R6";
        cyc(8'h11, 8'd4, 1'b1, 1'b0);
        for (int k = 0; k < 15; k++) begin
            cyc(8'h11, 8'd0, 1'b0, 1'b1);
            cyc(8'h11, 8'd0, 1'b0, 1'b1);
            cyc(8'h11, 8'd4, 1'b1, 1'b0);
        end
        // R7: stopping read, on both phases of the reference enable
        tag = "R7";
        idle_read(2);
        cyc(8'h01, 8'h00, 1'b0, 1'b1);
        idle_read(10);
        cyc(8'h11, 8'd9, 1'b1, 1'b0);
        idle_read(3);
        cyc(8'h01, 8'h00, 1'b0, 1'b1);
        cyc(8'h01, 8'h00, 1'b0, 1'b1);
        idle_read(10);
        // R8: watchdog expiry pulse
        tag = "R8";
        cyc(8'h11, 8'd3, 1'b1, 1'b0);
        idle_read(12);
        // R10: accesses during the pulse are ignored
        tag = "R10";
        cyc(8'h11, 8'd9, 1'b1, 1'b0);
        cyc(8'h01, 8'h00, 1'b0, 1'b1);
        idle_read(4);
        cyc(8'h11, 8'd7, 1'b1, 1'b0);
        tag = "R8";
        idle_read(40);
        // R4: restart after release
        tag = "R4";
        cyc(8'h10, 8'h00, 1'b1, 1'b0);
        cyc(8'h11, 8'd2, 1'b1, 1'b0);
        idle_read(10);
        summary();
    end
endmodule